// File: doc/BRIEF.md
# Instruction Decoder with Immediate Extender

This block turns one 32-bit instruction word of a small load/store register machine into a registered bundle of control signals. The machine has two encodings. Both place the 6-bit opcode in bits 31:26, the first source register in bits 25:21 and the second register index in bits 20:16. The register encoding adds a third register index in bits 15:11 and a 6-bit function code in bits 5:0. The immediate encoding carries a 16-bit immediate in bits 15:0. All arithmetic and logic operations share a single opcode and are told apart by the function code. Each immediate instruction has its own extension rule: sign, zero or upper-half placement.

The decoder takes an instruction and a valid strobe. One clock later it presents the register indices, an ALU operation select, an ALU second-operand source, register-write, memory-read and memory-write strobes, a byte/word size, a writeback source, the 32-bit extended immediate and an illegal-instruction flag. The register file, the ALU, the memory and the program counter are outside the block.

Top module: `instr_decode_unit`

## Requirements
- R1: All outputs are registered. `out_valid` equals the `in_valid` of the previous cycle, and a synchronous active-high `rst` forces every output to zero.
- R2: `src_a_idx` is bits 25:21 and `dst_idx` is bits 20:16. `src_b_idx` is bits 15:11 when the opcode is 100000 and bits 20:16 for every other opcode.
- R3: For opcode 100000 with function code 110000..111111, `alu_sel` = func[3:0], `reg_wr`=1 and `wb_sel`=0 (ALU). `alu_b_imm`=1 only for function codes 111000..111100, the shift and rotate group, and 0 for the rest.
- R4: Within opcode 100000, `imm_ext` is the zero-extended bits 15:0 for function codes 111000..111100 and 0 for every other function code.
- R5: Opcode 111000 gives `imm_ext` = sign-extended imm. Opcode 111001 gives `imm_ext` = imm<<16. Both set `reg_wr`=1, `wb_sel`=2 (immediate), `alu_b_imm`=0 and `alu_sel`=0.
- R6: Opcode 110000 sign-extends the immediate and sets `alu_sel`=0. Opcodes 110010 and 110011 zero-extend it and set `alu_sel`=2 and 3. All three set `alu_b_imm`=1, `reg_wr`=1 and `wb_sel`=0.
- R7: The loads are 000011 (byte, `mem_byte`=1) and 001111 (word, `mem_byte`=0). They set `mem_rd`=1, `reg_wr`=1, `wb_sel`=1 (memory), `alu_b_imm`=1, `alu_sel`=0 and a sign-extended immediate. `mem_rd` and `mem_wr` are never 1 together.
- R8: The stores are 000111 (byte, `mem_byte`=1) and 011111 (word). They set `mem_wr`=1, `alu_b_imm`=1, `alu_sel`=0, a sign-extended immediate and `reg_wr`=0. Their data register index appears on `src_b_idx`.
- R9: The branches are 111111, 010000 and 010001. They give a sign-extended immediate, and the last two set `alu_sel`=1 for the compare. Opcode 111110 gives `imm_ext`=0. No branch asserts `reg_wr`, `mem_rd` or `mem_wr`.
- R10: Any other opcode, and opcode 100000 with func[5:4] not 11, sets `illegal`=1. It clears every control output and `imm_ext`, while the register index outputs still follow R2.
- R11: When `in_valid` is 0, the next cycle has `reg_wr`, `mem_rd`, `mem_wr` and `illegal` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word is present |
| instr | input | 32 | Instruction word |
| out_valid | output | 1 | Decoded bundle is valid |
| src_a_idx | output | 5 | First source register index |
| src_b_idx | output | 5 | Second source register index |
| dst_idx | output | 5 | Destination register index |
| alu_sel | output | 4 | ALU operation select |
| alu_b_imm | output | 1 | ALU second operand is the immediate |
| reg_wr | output | 1 | Register write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_byte | output | 1 | Memory access is one byte |
| wb_sel | output | 2 | Writeback source: 0 ALU, 1 memory, 2 immediate |
| imm_ext | output | 32 | Extended immediate |
| illegal | output | 1 | Instruction is not in the set |

## Verification
Every result of this block appears exactly one clock edge after its instruction is presented, and the reset state appears one edge after `rst` is raised. The bench changes `instr` and `in_valid` on the falling edge, lets one rising edge pass, and compares the whole output bundle at the next falling edge. That edge is the first at which the new result can show, and it comes before the next stimulus replaces it. The in-RTL properties apply the same one-cycle offset through `$past`, gated until a full cycle has passed since reset.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int XLEN     = 32;
  localparam int IMM_W    = 16;
  localparam int RIDX_W   = 5;
  localparam int OPC_W    = 6;
  localparam int FUNC_W   = 6;
  localparam int ALUSEL_W = 4;

  typedef enum logic [1:0] {
    EXT_NONE  = 2'd0,
    EXT_SIGN  = 2'd1,
    EXT_ZERO  = 2'd2,
    EXT_UPPER = 2'd3
  } ext_kind_e;

  typedef enum logic [1:0] {
    WB_ALU = 2'd0,
    WB_MEM = 2'd1,
    WB_IMM = 2'd2
  } wb_src_e;

  localparam logic [OPC_W-1:0] OP_GROUP = 6'b100000;
  localparam logic [OPC_W-1:0] OP_LDIMM = 6'b111000;
  localparam logic [OPC_W-1:0] OP_LDUP  = 6'b111001;
  localparam logic [OPC_W-1:0] OP_ADDIM = 6'b110000;
  localparam logic [OPC_W-1:0] OP_ANDIM = 6'b110010;
  localparam logic [OPC_W-1:0] OP_ORIM  = 6'b110011;
  localparam logic [OPC_W-1:0] OP_JREL  = 6'b111111;
  localparam logic [OPC_W-1:0] OP_JREG  = 6'b111110;
  localparam logic [OPC_W-1:0] OP_JEQ   = 6'b010000;
  localparam logic [OPC_W-1:0] OP_JNE   = 6'b010001;
  localparam logic [OPC_W-1:0] OP_LDB   = 6'b000011;
  localparam logic [OPC_W-1:0] OP_LDW   = 6'b001111;
  localparam logic [OPC_W-1:0] OP_STB   = 6'b000111;
  localparam logic [OPC_W-1:0] OP_STW   = 6'b011111;

  localparam logic [FUNC_W-1:0] FN_SHIFT_LO = 6'b111000;
  localparam logic [FUNC_W-1:0] FN_SHIFT_HI = 6'b111100;

  localparam logic [ALUSEL_W-1:0] ALU_ADD = 4'd0;
  localparam logic [ALUSEL_W-1:0] ALU_SUB = 4'd1;
  localparam logic [ALUSEL_W-1:0] ALU_AND = 4'd2;
  localparam logic [ALUSEL_W-1:0] ALU_OR  = 4'd3;

  typedef struct packed {
    logic [ALUSEL_W-1:0] alu_sel;
    logic                b_imm;
    logic                reg_wr;
    logic                mem_rd;
    logic                mem_wr;
    logic                mem_byte;
    wb_src_e             wb;
    ext_kind_e           ext;
    logic                illegal;
  } ctrl_t;
endpackage

// File: rtl/idec_ctrl.sv
module idec_ctrl
  import idec_pkg::*;
#(
  parameter int OPCW  = OPC_W,
  parameter int FUNCW = FUNC_W
) (
  input  logic [OPCW-1:0]  opcode,
  input  logic [FUNCW-1:0] func,
  output ctrl_t            ctrl
);
  localparam int GRP_MSB = FUNCW - 1;
  localparam int GRP_LSB = FUNCW - 2;

  logic func_legal;
  logic func_shift;

  assign func_legal = (func[GRP_MSB:GRP_LSB] == 2'b11);
  assign func_shift = (func >= FN_SHIFT_LO) && (func <= FN_SHIFT_HI);

  always_comb begin
    ctrl = '0;
    unique case (opcode)
      OP_GROUP: begin
        if (func_legal) begin
          ctrl.alu_sel = func[ALUSEL_W-1:0];
          ctrl.reg_wr  = 1'b1;
          ctrl.wb      = WB_ALU;
          if (func_shift) begin
            ctrl.b_imm = 1'b1;
            ctrl.ext   = EXT_ZERO;
          end
        end else begin
          ctrl.illegal = 1'b1;
        end
      end
      OP_LDIMM: begin
        ctrl.reg_wr = 1'b1;
        ctrl.wb     = WB_IMM;
        ctrl.ext    = EXT_SIGN;
      end
      OP_LDUP: begin
        ctrl.reg_wr = 1'b1;
        ctrl.wb     = WB_IMM;
        ctrl.ext    = EXT_UPPER;
      end
      OP_ADDIM: begin
        ctrl.alu_sel = ALU_ADD;
        ctrl.b_imm   = 1'b1;
        ctrl.reg_wr  = 1'b1;
        ctrl.ext     = EXT_SIGN;
      end
      OP_ANDIM: begin
        ctrl.alu_sel = ALU_AND;
        ctrl.b_imm   = 1'b1;
        ctrl.reg_wr  = 1'b1;
        ctrl.ext     = EXT_ZERO;
      end
      OP_ORIM: begin
        ctrl.alu_sel = ALU_OR;
        ctrl.b_imm   = 1'b1;
        ctrl.reg_wr  = 1'b1;
        ctrl.ext     = EXT_ZERO;
      end
      OP_LDB, OP_LDW: begin
        ctrl.alu_sel  = ALU_ADD;
        ctrl.b_imm    = 1'b1;
        ctrl.reg_wr   = 1'b1;
        ctrl.mem_rd   = 1'b1;
        ctrl.mem_byte = (opcode == OP_LDB);
        ctrl.wb       = WB_MEM;
        ctrl.ext      = EXT_SIGN;
      end
      OP_STB, OP_STW: begin
        ctrl.alu_sel  = ALU_ADD;
        ctrl.b_imm    = 1'b1;
        ctrl.mem_wr   = 1'b1;
        ctrl.mem_byte = (opcode == OP_STB);
        ctrl.ext      = EXT_SIGN;
      end
      OP_JREL: begin
        ctrl.ext = EXT_SIGN;
      end
      OP_JREG: begin
        ctrl.ext = EXT_NONE;
      end
      OP_JEQ, OP_JNE: begin
        ctrl.alu_sel = ALU_SUB;
        ctrl.ext     = EXT_SIGN;
      end
      default: begin
        ctrl.illegal = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/idec_imm_ext.sv
module idec_imm_ext
  import idec_pkg::*;
#(
  parameter int IMMW = IMM_W,
  parameter int XW   = XLEN
) (
  input  logic [IMMW-1:0] imm,
  input  ext_kind_e       kind,
  output logic [XW-1:0]   imm_out
);
  localparam int PAD = XW - IMMW;

  logic [XW-1:0] sign_v;
  logic [XW-1:0] zero_v;
  logic [XW-1:0] upper_v;

  assign sign_v = {{PAD{imm[IMMW-1]}}, imm};
  assign zero_v = {{PAD{1'b0}}, imm};

  generate
    if (XW >= 2 * IMMW) begin : g_upper_fits
      assign upper_v = zero_v << IMMW;
    end else begin : g_upper_clipped
      assign upper_v = '0;
    end
  endgenerate

  always_comb begin
    unique case (kind)
      EXT_SIGN:  imm_out = sign_v;
      EXT_ZERO:  imm_out = zero_v;
      EXT_UPPER: imm_out = upper_v;
      default:   imm_out = '0;
    endcase
  end
endmodule

// File: rtl/idec_out_reg.sv
module idec_out_reg
  import idec_pkg::*;
#(
  parameter int XW  = XLEN,
  parameter int RIW = RIDX_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  ctrl_t               ctrl,
  input  logic [RIW-1:0]      ra_in,
  input  logic [RIW-1:0]      rb_in,
  input  logic [RIW-1:0]      rd_in,
  input  logic [XW-1:0]       imm_in,
  output logic                out_valid,
  output logic [RIW-1:0]      ra_q,
  output logic [RIW-1:0]      rb_q,
  output logic [RIW-1:0]      rd_q,
  output logic [ALUSEL_W-1:0] alu_sel_q,
  output logic                b_imm_q,
  output logic                reg_wr_q,
  output logic                mem_rd_q,
  output logic                mem_wr_q,
  output logic                mem_byte_q,
  output logic [1:0]          wb_q,
  output logic [XW-1:0]       imm_q,
  output logic                illegal_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      ra_q       <= '0;
      rb_q       <= '0;
      rd_q       <= '0;
      alu_sel_q  <= '0;
      b_imm_q    <= 1'b0;
      reg_wr_q   <= 1'b0;
      mem_rd_q   <= 1'b0;
      mem_wr_q   <= 1'b0;
      mem_byte_q <= 1'b0;
      wb_q       <= '0;
      imm_q      <= '0;
      illegal_q  <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      ra_q       <= ra_in;
      rb_q       <= rb_in;
      rd_q       <= rd_in;
      alu_sel_q  <= ctrl.alu_sel;
      b_imm_q    <= ctrl.b_imm;
      reg_wr_q   <= in_valid & ctrl.reg_wr;
      mem_rd_q   <= in_valid & ctrl.mem_rd;
      mem_wr_q   <= in_valid & ctrl.mem_wr;
      mem_byte_q <= ctrl.mem_byte;
      wb_q       <= ctrl.wb;
      imm_q      <= imm_in;
      illegal_q  <= in_valid & ctrl.illegal;
    end
  end

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!reg_wr_q && !mem_rd_q && !mem_wr_q && !illegal_q));

  // R7
  mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd_q, mem_wr_q}));

  // R8
  store_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_q |-> !reg_wr_q);
endmodule

// File: rtl/instr_decode_unit.sv
module instr_decode_unit
  import idec_pkg::*;
#(
  parameter int XW   = XLEN,
  parameter int IMMW = IMM_W,
  parameter int RIW  = RIDX_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  output logic            out_valid,
  output logic [4:0]      src_a_idx,
  output logic [4:0]      src_b_idx,
  output logic [4:0]      dst_idx,
  output logic [3:0]      alu_sel,
  output logic            alu_b_imm,
  output logic            reg_wr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            mem_byte,
  output logic [1:0]      wb_sel,
  output logic [31:0]     imm_ext,
  output logic            illegal
);
  localparam int OPC_LSB = XW - OPC_W;
  localparam int RA_LSB  = OPC_LSB - RIW;
  localparam int RD_LSB  = RA_LSB - RIW;
  localparam int RT_LSB  = RD_LSB - RIW;

  logic [OPC_W-1:0]  opcode;
  logic [FUNC_W-1:0] func;
  logic [RIW-1:0]    ra_f, rd_f, rt_f, rb_sel;
  logic [IMMW-1:0]   imm_f;
  logic [XW-1:0]     imm_x;
  ctrl_t             ctrl;

  assign opcode = instr[XW-1:OPC_LSB];
  assign ra_f   = instr[OPC_LSB-1:RA_LSB];
  assign rd_f   = instr[RA_LSB-1:RD_LSB];
  assign rt_f   = instr[RD_LSB-1:RT_LSB];
  assign imm_f  = instr[IMMW-1:0];
  assign func   = instr[FUNC_W-1:0];
  assign rb_sel = (opcode == OP_GROUP) ? rt_f : rd_f;

  idec_ctrl #(.OPCW(OPC_W), .FUNCW(FUNC_W)) u_ctrl (
    .opcode (opcode),
    .func   (func),
    .ctrl   (ctrl)
  );

  idec_imm_ext #(.IMMW(IMMW), .XW(XW)) u_ext (
    .imm     (imm_f),
    .kind    (ctrl.ext),
    .imm_out (imm_x)
  );

  idec_out_reg #(.XW(XW), .RIW(RIW)) u_oreg (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .ctrl       (ctrl),
    .ra_in      (ra_f),
    .rb_in      (rb_sel),
    .rd_in      (rd_f),
    .imm_in     (imm_x),
    .out_valid  (out_valid),
    .ra_q       (src_a_idx),
    .rb_q       (src_b_idx),
    .rd_q       (dst_idx),
    .alu_sel_q  (alu_sel),
    .b_imm_q    (alu_b_imm),
    .reg_wr_q   (reg_wr),
    .mem_rd_q   (mem_rd),
    .mem_wr_q   (mem_wr),
    .mem_byte_q (mem_byte),
    .wb_q       (wb_sel),
    .imm_q      (imm_ext),
    .illegal_q  (illegal)
  );

  logic seen_q;
  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= 1'b1;
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst || !seen_q)
    out_valid == $past(in_valid));

  // R2
  field_a_chk: assert property (@(posedge clk) disable iff (rst || !seen_q)
    src_a_idx == $past(instr[25:21]) && dst_idx == $past(instr[20:16]));

  // R5
  upper_low_zero_chk: assert property (@(posedge clk) disable iff (rst || !seen_q)
    (out_valid && $past(instr[31:26] == OP_LDUP)) |-> (imm_ext[15:0] == '0));

  // R9
  branch_quiet_chk: assert property (@(posedge clk) disable iff (rst || !seen_q)
    $past(instr[31:26] == OP_JREL || instr[31:26] == OP_JREG ||
          instr[31:26] == OP_JEQ  || instr[31:26] == OP_JNE)
    |-> (!reg_wr && !mem_rd && !mem_wr));

  // R10
  illegal_clear_chk: assert property (@(posedge clk) disable iff (rst || !seen_q)
    illegal |-> (!reg_wr && !mem_rd && !mem_wr && imm_ext == '0 && alu_sel == '0));
endmodule

// File: tb/instr_decode_unit_test.sv
module instr_decode_unit_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic        out_valid, alu_b_imm, reg_wr, mem_rd, mem_wr, mem_byte, illegal;
  logic [4:0]  src_a_idx, src_b_idx, dst_idx;
  logic [3:0]  alu_sel;
  logic [1:0]  wb_sel;
  logic [31:0] imm_ext;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  instr_decode_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .out_valid(out_valid), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .dst_idx(dst_idx), .alu_sel(alu_sel), .alu_b_imm(alu_b_imm),
    .reg_wr(reg_wr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_byte(mem_byte),
    .wb_sel(wb_sel), .imm_ext(imm_ext), .illegal(illegal)
  );

  function automatic logic [58:0] expect_bundle(input logic [31:0] w);
    logic [5:0]  op, fn;
    logic [31:0] se, ze, ie;
    logic [3:0]  alu;
    logic [1:0]  wb;
    logic [4:0]  sb;
    logic        bi, rw, mr, mw, mb, il;
    op = w[31:26]; fn = w[5:0];
    se = {{16{w[15]}}, w[15:0]};
    ze = {16'h0, w[15:0]};
    ie = '0; alu = '0; wb = '0; sb = w[20:16];
    bi = 0; rw = 0; mr = 0; mw = 0; mb = 0; il = 0;
    case (op)
      6'b100000: begin
        sb = w[15:11];
        if (fn[5:4] != 2'b11) il = 1;
        else begin
          alu = fn[3:0]; rw = 1;
          if (fn >= 6'b111000 && fn <= 6'b111100) begin bi = 1; ie = ze; end
        end
      end
      6'b111000: begin rw = 1; wb = 2; ie = se; end
      6'b111001: begin rw = 1; wb = 2; ie = {w[15:0], 16'h0}; end
      6'b110000: begin rw = 1; bi = 1; ie = se; end
      6'b110010: begin rw = 1; bi = 1; alu = 2; ie = ze; end
      6'b110011: begin rw = 1; bi = 1; alu = 3; ie = ze; end
      6'b000011: begin rw = 1; mr = 1; mb = 1; wb = 1; bi = 1; ie = se; end
      6'b001111: begin rw = 1; mr = 1; wb = 1; bi = 1; ie = se; end
      6'b000111: begin mw = 1; mb = 1; bi = 1; ie = se; end
      6'b011111: begin mw = 1; bi = 1; ie = se; end
      6'b111111: ie = se;
      6'b111110: ie = '0;
      6'b010000, 6'b010001: begin alu = 1; ie = se; end
      default: il = 1;
    endcase
    return {w[25:21], sb, w[20:16], alu, bi, rw, mr, mw, mb, wb, ie, il};
  endfunction

  function automatic string req_of(input logic [31:0] w);
    case (w[31:26])
      6'b100000: return (w[5:4] != 2'b11) ? "R10" :
                        ((w[5:0] >= 6'b111000 && w[5:0] <= 6'b111100) ? "R4" : "R3");
      6'b111000, 6'b111001: return "R5";
      6'b110000, 6'b110010, 6'b110011: return "R6";
      6'b000011, 6'b001111: return "R7";
      6'b000111, 6'b011111: return "R8";
      6'b111111, 6'b111110, 6'b010000, 6'b010001: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [5:0] pick_op(input int k);
    case (k)
      0: return 6'b100000;  1: return 6'b111000;  2: return 6'b111001;
      3: return 6'b110000;  4: return 6'b110010;  5: return 6'b110011;
      6: return 6'b000011;  7: return 6'b001111;  8: return 6'b000111;
      9: return 6'b011111; 10: return 6'b111111; 11: return 6'b111110;
     12: return 6'b010000; 13: return 6'b010001; 14: return 6'b100000;
      default: return 6'($urandom);
    endcase
  endfunction

  function automatic logic [58:0] actual_bundle();
    return {src_a_idx, src_b_idx, dst_idx, alu_sel, alu_b_imm, reg_wr,
            mem_rd, mem_wr, mem_byte, wb_sel, imm_ext, illegal};
  endfunction

  task automatic apply(input logic [31:0] w, input logic v);
    logic [58:0] exp_b, act_b;
    instr = w; in_valid = v;
    @(negedge clk);
    checks++;
    if (out_valid !== v) begin
      fails++;
      $display("FAIL R1 out_valid instr=%h actual=%b expected=%b", w, out_valid, v);
    end
    checks++;
    if (v) begin
      exp_b = expect_bundle(w);
      act_b = actual_bundle();
      if (act_b !== exp_b) begin
        fails++;
        $display("FAIL %s/R2 instr=%h actual=%h expected=%h", req_of(w), w, act_b, exp_b);
      end
    end else begin
      // R11: strobes quiet when no instruction is presented
      if ({reg_wr, mem_rd, mem_wr, illegal} !== 4'b0) begin
        fails++;
        $display("FAIL R11 instr=%h actual=%b expected=0000", w,
                 {reg_wr, mem_rd, mem_wr, illegal});
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0D1C));
    instr = 32'hFFFF_FFFF; in_valid = 1'b1; rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || actual_bundle() !== '0) begin
      fails++;
      $display("FAIL R1 reset actual=%h/%b expected=0/0", actual_bundle(), out_valid);
    end
    rst = 1'b0;

    // directed corners
    apply({6'b100000, 5'd3, 5'd4, 5'd5, 5'd0, 6'b110000}, 1'b1); // R3 add
    apply({6'b100000, 5'd31, 5'd1, 5'd2, 5'd9, 6'b111111}, 1'b1); // R3 xor
    apply({6'b100000, 5'd7, 5'd8, 16'hF83C}, 1'b1);               // R4 ror, zero-ext
    apply({6'b100000, 5'd7, 5'd8, 16'hF835}, 1'b1);               // R4 nor, imm 0
    apply({6'b100000, 5'd1, 5'd2, 16'h002F}, 1'b1);               // R10 bad func
    apply({6'b111000, 5'd0, 5'd9, 16'h8001}, 1'b1);               // R5 li negative
    apply({6'b111001, 5'd0, 5'd9, 16'hBEEF}, 1'b1);               // R5 lui
    apply({6'b110000, 5'd2, 5'd3, 16'hFFFF}, 1'b1);               // R6 addi
    apply({6'b110010, 5'd2, 5'd3, 16'hFFFF}, 1'b1);               // R6 andi
    apply({6'b110011, 5'd2, 5'd3, 16'h8000}, 1'b1);               // R6 ori
    apply({6'b000011, 5'd4, 5'd5, 16'hFFF0}, 1'b1);               // R7 lb
    apply({6'b001111, 5'd4, 5'd5, 16'h0010}, 1'b1);               // R7 lw
    apply({6'b000111, 5'd6, 5'd12, 16'h8004}, 1'b1);              // R8 sb
    apply({6'b011111, 5'd6, 5'd12, 16'h0004}, 1'b1);              // R8 sw
    apply({6'b111111, 5'd0, 5'd0, 16'hFFFE}, 1'b1);               // R9 b
    apply({6'b111110, 5'd5, 5'd0, 16'h1234}, 1'b1);               // R9 br
    apply({6'b010000, 5'd1, 5'd2, 16'h8000}, 1'b1);               // R9 beq
    apply({6'b010001, 5'd1, 5'd2, 16'h0003}, 1'b1);               // R9 bne
    apply({6'b000000, 5'd1, 5'd2, 16'h0003}, 1'b1);               // R10 bad opcode
    apply({6'b000011, 5'd4, 5'd5, 16'h0001}, 1'b0);               // R11 idle load
    apply({6'b101010, 5'd4, 5'd5, 16'h0001}, 1'b0);               // R11 idle illegal

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [31:0] w;
      logic [5:0]  op;
      logic        v;
      w  = $urandom;
      op = pick_op(int'($urandom_range(0, 17)));
      w[31:26] = op;
      if (op == 6'b100000 && $urandom_range(0, 3) != 0) w[5:4] = 2'b11;
      v = ($urandom_range(0, 7) != 0);
      apply(w, v);
    end

    // R1: reset mid-stream
    instr = {6'b000011, 5'd4, 5'd5, 16'h0001}; in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || actual_bundle() !== '0) begin
      fails++;
      $display("FAIL R1 rerun reset actual=%h/%b expected=0/0", actual_bundle(), out_valid);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule